// File: doc/BRIEF.md
# Shared Buffer Admission Controller

This block decides, one packet at a time, whether an arriving packet may occupy cells in a packet buffer that all output-port queues share. Each port owns a small guaranteed reserve of cells. Everything above the sum of those reserves is one common pool, and the pool is handed to whichever port asks first. This lets a single busy queue grow well beyond an even split of the storage while the other queues stay short. The block only does the accounting. The cell memory and the address free list are outside it.

An enqueue request carries a destination port and a length in cells. The block charges the port's unused reserve first and takes any remainder from the free shared pool. A packet that does not fit is dropped whole, and no cells are charged for it. A release event returns cells from a port's queue, and cells held in the shared pool are given back first. One cycle after each request the block reports the verdict, the port, and the depth the destination queue had when the packet arrived. It keeps a live occupancy count for every port and a count of shared-pool cells in use. Any configuration in which the reserves add up to more than the total capacity is refused at elaboration.

Top module: `sba_admission_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every port occupancy is 0, the shared-pool count is 0 and `res_valid` is 0.
- R2: A request is accepted if and only if its length is at least 1, its port index is below NUM_PORTS, and its length is no greater than the port's unused reserve plus the free shared-pool cells. The verdict appears on `res_valid`/`res_accept` in the cycle after the request, and `res_port` echoes the requested port.
- R3: A dropped request, including one of length 0, changes no port occupancy and does not change the shared-pool count.
- R4: The cells of an accepted packet come from the port's reserve first. `pool_used` rises only by the part of the length that exceeds the port's unused reserve, and a port never holds more than RESERVE_CELLS reserve cells.
- R5: A single port's occupancy may exceed TOTAL_CELLS/NUM_PORTS while the other ports are idle, up to RESERVE_CELLS plus the pool size.
- R6: A port whose reserve is unused can still be admitted up to RESERVE_CELLS cells when the shared pool is completely used.
- R7: A release of c cells on a port returns min(c, that port's shared-pool cells) to the pool. The rest of the release comes out of the port's reserve.
- R8: When an enqueue and a release occur in the same cycle, including on the same port, both are applied to the counters. Both are computed from the counter values of that cycle.
- R9: `res_depth` equals the destination port's own occupancy in the request cycle, before this packet's cells are added. It is not the total buffer occupancy.
- R10: `pool_used` never exceeds TOTAL_CELLS - NUM_PORTS*RESERVE_CELLS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue request present |
| enq_port | input | PORT_W | Destination port of the request |
| enq_len | input | LEN_W | Packet length in cells |
| rel_valid | input | 1 | Release event present |
| rel_port | input | PORT_W | Port whose cells are released |
| rel_cells | input | LEN_W | Number of cells released; must not exceed that port's occupancy |
| res_valid | output | 1 | Verdict for the previous cycle's request |
| res_accept | output | 1 | 1 = admitted, 0 = dropped |
| res_port | output | PORT_W | Port of the reported request |
| res_depth | output | CNT_W | Destination queue depth at enqueue time |
| occ_flat | output | NUM_PORTS*CNT_W | Per-port occupancy, port p at bits p*CNT_W upward |
| pool_used | output | CNT_W | Shared-pool cells in use |

## Verification
The bench first runs a directed sequence. A small packet on an empty port shows that cells come from the reserve only. A packet that straddles the end of the reserve shows the split between reserve and pool. One port is then filled until the pool is exhausted, which separates the shared-pool policy from a fixed per-port split. A second port is admitted into its reserve while the pool is full, which shows the guarantee holds. Oversized and zero-length requests test the whole-drop rule. Release and enqueue on the same cycle test that neither update is lost, and a depth read on a deep queue tells per-queue depth apart from total occupancy. A long random mix of enqueues and releases is then compared on every clock against a behavioural model of the counters.

// File: rtl/sba_pkg.sv
// Package sba_pkg
// Shared helpers for the shared-buffer admission controller.
// Assumes all counts fit in 32-bit unsigned arithmetic.
package sba_pkg;

    // Smaller of two cell counts.
    function automatic int unsigned cells_min(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/sba_admit.sv
// Module sba_admit
// Combinational admission decision for one request. Charges the port's
// unused reserve first and then the free shared pool, and admits the packet
// only when all of its cells fit. Assumes that the counter inputs are the
// current register values.
module sba_admit #(
    parameter int RESERVE_CELLS = 32,
    parameter int POOL_CELLS    = 128,
    parameter int CNT_W         = 9,
    parameter int LEN_W         = 6
) (
    input  logic             req_valid,
    input  logic             port_ok,
    input  logic [LEN_W-1:0] req_len,
    input  logic [CNT_W-1:0] port_res_used,
    input  logic [CNT_W-1:0] pool_used,
    output logic             admit,
    output logic [CNT_W-1:0] take_res,
    output logic [CNT_W-1:0] take_shr
);
    import sba_pkg::*;

    logic [CNT_W:0]   res_free;
    logic [CNT_W:0]   pool_free;
    logic [CNT_W:0]   len_ext;
    logic [CNT_W:0]   room;

    // Free reserve and free pool space, and the total room for this request.
    always_comb begin
        res_free  = (CNT_W+1)'(RESERVE_CELLS) - {1'b0, port_res_used};
        pool_free = (CNT_W+1)'(POOL_CELLS) - {1'b0, pool_used};
        len_ext   = (CNT_W+1)'(req_len);
        room      = res_free + pool_free;
    end

    // Verdict and the split of the packet between reserve and pool.
    always_comb begin
        admit    = req_valid && port_ok && (req_len != '0) && (len_ext <= room);
        take_res = '0;
        take_shr = '0;
        if (admit) begin
            take_res = CNT_W'(cells_min(int'(len_ext), int'(res_free)));
            take_shr = CNT_W'(len_ext) - take_res;
        end
    end

endmodule

// File: rtl/sba_release_split.sv
// Module sba_release_split
// Splits a release between the shared pool and the reserve, taking the
// port's shared-pool cells first. Assumes the release never exceeds the
// port's occupancy.
module sba_release_split #(
    parameter int CNT_W = 9,
    parameter int LEN_W = 6
) (
    input  logic             rel_valid,
    input  logic [LEN_W-1:0] rel_cells,
    input  logic [CNT_W-1:0] port_shr_used,
    output logic [CNT_W-1:0] give_res,
    output logic [CNT_W-1:0] give_shr
);
    import sba_pkg::*;

    logic [CNT_W-1:0] cells_ext;

    // Shared cells go back first and the rest comes from the reserve.
    always_comb begin
        cells_ext = CNT_W'(rel_cells);
        give_shr  = '0;
        give_res  = '0;
        if (rel_valid) begin
            give_shr = CNT_W'(cells_min(int'(cells_ext), int'(port_shr_used)));
            give_res = cells_ext - give_shr;
        end
    end

endmodule

// File: rtl/sba_port_acct.sv
// Module sba_port_acct
// Counters for one port: reserve cells held and shared cells held. Applies an
// enqueue charge and a release credit in the same cycle. Assumes the credits
// never exceed the amounts held.
module sba_port_acct #(
    parameter int RESERVE_CELLS = 32,
    parameter int CNT_W         = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_hit,
    input  logic [CNT_W-1:0] take_res,
    input  logic [CNT_W-1:0] take_shr,
    input  logic             rel_hit,
    input  logic [CNT_W-1:0] give_res,
    input  logic [CNT_W-1:0] give_shr,
    output logic [CNT_W-1:0] res_used,
    output logic [CNT_W-1:0] shr_used
);
    logic [CNT_W-1:0] add_res, add_shr, sub_res, sub_shr;

    // Keep only the charges and credits that address this port.
    always_comb begin
        add_res = enq_hit ? take_res : '0;
        add_shr = enq_hit ? take_shr : '0;
        sub_res = rel_hit ? give_res : '0;
        sub_shr = rel_hit ? give_shr : '0;
    end

    // Update both counters with the combined enqueue and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_used <= '0;
            shr_used <= '0;
        end else begin
            res_used <= res_used + add_res - sub_res;
            shr_used <= shr_used + add_shr - sub_shr;
        end
    end

    // R4
    reserve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_used <= CNT_W'(RESERVE_CELLS));

    // R8
    both_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_hit && rel_hit) |=>
        (res_used + shr_used == $past(res_used) + $past(shr_used)
            + $past(take_res) + $past(take_shr) - $past(give_res) - $past(give_shr)));

endmodule

// File: rtl/sba_pool.sv
// Module sba_pool
// Count of shared-pool cells in use across all ports. Assumes that the
// charge and the credit come from the selected ports' splits.
module sba_pool #(
    parameter int POOL_CELLS = 128,
    parameter int CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] add_cells,
    input  logic [CNT_W-1:0] sub_cells,
    output logic [CNT_W-1:0] pool_used
);
    // Net change of the pool occupancy each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pool_used <= '0;
        else        pool_used <= pool_used + add_cells - sub_cells;
    end

    // R10
    pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pool_used <= CNT_W'(POOL_CELLS));

endmodule

// File: rtl/sba_admission_ctrl.sv
// Module sba_admission_ctrl
// Admission control for a buffer shared by NUM_PORTS output queues. Each port
// has a reserve of RESERVE_CELLS cells, and the remainder is a pool served
// first come, first served. The verdict is registered one cycle after the
// request. Assumes that a release never exceeds its port's occupancy and
// that the destination port is final when the request is made.
module sba_admission_ctrl #(
    parameter int NUM_PORTS     = 4,
    parameter int TOTAL_CELLS   = 256,
    parameter int RESERVE_CELLS = TOTAL_CELLS / (2 * NUM_PORTS),
    parameter int LEN_W         = 6,
    localparam int PORT_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int CNT_W        = $clog2(TOTAL_CELLS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enq_valid,
    input  logic [PORT_W-1:0]          enq_port,
    input  logic [LEN_W-1:0]           enq_len,
    input  logic                       rel_valid,
    input  logic [PORT_W-1:0]          rel_port,
    input  logic [LEN_W-1:0]           rel_cells,
    output logic                       res_valid,
    output logic                       res_accept,
    output logic [PORT_W-1:0]          res_port,
    output logic [CNT_W-1:0]           res_depth,
    output logic [NUM_PORTS*CNT_W-1:0] occ_flat,
    output logic [CNT_W-1:0]           pool_used
);
    localparam int POOL_CELLS = TOTAL_CELLS - NUM_PORTS * RESERVE_CELLS;

    // Refuse reserves that together exceed the buffer.
    if (NUM_PORTS * RESERVE_CELLS > TOTAL_CELLS) begin : g_bad_cfg
        $error("sba_admission_ctrl: reserves exceed total capacity");
    end

    logic [CNT_W-1:0] res_arr [NUM_PORTS];
    logic [CNT_W-1:0] shr_arr [NUM_PORTS];
    logic             enq_port_ok, rel_port_ok;
    logic [CNT_W-1:0] sel_res, sel_shr, rel_shr_sel;
    logic             admit;
    logic [CNT_W-1:0] take_res, take_shr, give_res, give_shr;

    // Check the port indices and pick the addressed ports' counters.
    always_comb begin
        enq_port_ok = int'(enq_port) < NUM_PORTS;
        rel_port_ok = int'(rel_port) < NUM_PORTS;
        sel_res     = enq_port_ok ? res_arr[enq_port] : '0;
        sel_shr     = enq_port_ok ? shr_arr[enq_port] : '0;
        rel_shr_sel = rel_port_ok ? shr_arr[rel_port] : '0;
    end

    sba_admit #(
        .RESERVE_CELLS(RESERVE_CELLS), .POOL_CELLS(POOL_CELLS),
        .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) u_admit (
        .req_valid    (enq_valid),
        .port_ok      (enq_port_ok),
        .req_len      (enq_len),
        .port_res_used(sel_res),
        .pool_used    (pool_used),
        .admit        (admit),
        .take_res     (take_res),
        .take_shr     (take_shr)
    );

    sba_release_split #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_rel (
        .rel_valid    (rel_valid && rel_port_ok),
        .rel_cells    (rel_cells),
        .port_shr_used(rel_shr_sel),
        .give_res     (give_res),
        .give_shr     (give_shr)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        sba_port_acct #(.RESERVE_CELLS(RESERVE_CELLS), .CNT_W(CNT_W)) u_acct (
            .clk     (clk),
            .rst_n   (rst_n),
            .enq_hit (admit && (int'(enq_port) == p)),
            .take_res(take_res),
            .take_shr(take_shr),
            .rel_hit (rel_valid && (int'(rel_port) == p)),
            .give_res(give_res),
            .give_shr(give_shr),
            .res_used(res_arr[p]),
            .shr_used(shr_arr[p])
        );
        assign occ_flat[p*CNT_W +: CNT_W] = res_arr[p] + shr_arr[p];
    end

    sba_pool #(.POOL_CELLS(POOL_CELLS), .CNT_W(CNT_W)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_cells(take_shr),
        .sub_cells(give_shr),
        .pool_used(pool_used)
    );

    // Register the verdict and the queue depth seen at enqueue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_port   <= '0;
            res_depth  <= '0;
        end else begin
            res_valid  <= enq_valid;
            res_accept <= admit;
            res_port   <= enq_port;
            res_depth  <= sel_res + sel_shr;
        end
    end

    // R2
    verdict_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(enq_valid));

    // R3
    drop_no_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept && !$past(rel_valid)) |-> $stable(pool_used));

endmodule

// File: tb/sba_admission_ctrl_tb.sv
module sba_admission_ctrl_tb;
    localparam int N = 4, TOTAL = 256, RSV = 32, LW = 6;
    localparam int POOL = TOTAL - N * RSV;
    localparam int PW = 2, CW = 9;

    logic clk = 0, rst_n = 0;
    logic enq_valid = 0, rel_valid = 0;
    logic [PW-1:0] enq_port = 0, rel_port = 0;
    logic [LW-1:0] enq_len = 0, rel_cells = 0;
    logic res_valid, res_accept;
    logic [PW-1:0] res_port;
    logic [CW-1:0] res_depth, pool_used;
    logic [N*CW-1:0] occ_flat;

    int checks = 0, errors = 0;
    bit done = 0, started = 0;

    sba_admission_ctrl #(.NUM_PORTS(N), .TOTAL_CELLS(TOTAL), .RESERVE_CELLS(RSV), .LEN_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_port(enq_port), .enq_len(enq_len),
        .rel_valid(rel_valid), .rel_port(rel_port), .rel_cells(rel_cells),
        .res_valid(res_valid), .res_accept(res_accept), .res_port(res_port),
        .res_depth(res_depth), .occ_flat(occ_flat), .pool_used(pool_used));

    always #5 clk = ~clk;

    // Behavioural model state
    int mres[N], mshr[N], mpool;
    bit ev, ea; int ep, edp;

    function automatic int imin(int a, int b); return a < b ? a : b; endfunction
    function automatic int occ(int p); return int'(occ_flat[p*CW +: CW]); endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            for (int p = 0; p < N; p++) begin mres[p] = 0; mshr[p] = 0; end
            mpool = 0; ev = 0; ea = 0; ep = 0; edp = 0;
        end else begin
            int p, l, rf, pf, tr, ts, rp, c, gs, gr; bit acc;
            p = int'(enq_port); l = int'(enq_len);
            rf = RSV - mres[p]; pf = POOL - mpool;
            acc = enq_valid && l > 0 && l <= rf + pf;
            tr = acc ? imin(l, rf) : 0; ts = acc ? l - tr : 0;
            edp = mres[p] + mshr[p];
            rp = int'(rel_port); c = rel_valid ? int'(rel_cells) : 0;
            gs = imin(c, mshr[rp]); gr = c - gs;
            mres[rp] -= gr; mshr[rp] -= gs; mpool -= gs;
            mres[p] += tr; mshr[p] += ts; mpool += ts;
            ev = enq_valid; ea = acc; ep = p;
        end
    end

    // Compare against the model each clock (R1 R4 R7 R8 R9).
    always @(negedge clk) begin
        if (started && !done) begin
            for (int p = 0; p < N; p++)
                chk(occ(p) == mres[p] + mshr[p], "R8 occupancy", occ(p), mres[p] + mshr[p]);
            chk(int'(pool_used) == mpool, "R7 pool_used", int'(pool_used), mpool);
            chk(res_valid == ev, "R2 res_valid", res_valid, ev);
            if (ev) begin
                chk(res_accept == ea, "R2 accept", res_accept, ea);
                chk(int'(res_port) == ep, "R2 port", res_port, ep);
                chk(int'(res_depth) == edp, "R9 depth", res_depth, edp);
            end
        end
    end

    task automatic step(bit e, int p, int l, bit r, int rp, int c);
        enq_valid = e; enq_port = PW'(p); enq_len = LW'(l);
        rel_valid = r; rel_port = PW'(rp); rel_cells = LW'(c);
        @(negedge clk);
        enq_valid = 0; rel_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1
        for (int p = 0; p < N; p++) chk(occ(p) == 0, "R1 reset occupancy", occ(p), 0);
        chk(pool_used == 0 && !res_valid, "R1 reset pool/valid", int'(pool_used), 0);
        // R4 reserve first
        step(1, 0, 20, 0, 0, 0);
        chk(pool_used == 0, "R4 reserve only", int'(pool_used), 0);
        step(1, 0, 20, 0, 0, 0);
        chk(pool_used == 8, "R4 straddle", int'(pool_used), 8);
        // R5 one port beyond a 1/N share
        step(1, 0, 60, 0, 0, 0);
        step(1, 0, 60, 0, 0, 0);
        chk(occ(0) == RSV + POOL, "R5 deep port", occ(0), RSV + POOL);
        chk(occ(0) > TOTAL / N, "R5 beyond share", occ(0), TOTAL / N);
        // R3 whole drop
        step(1, 0, 1, 0, 0, 0);
        chk(res_valid && !res_accept, "R3 drop verdict", res_accept, 0);
        chk(occ(0) == RSV + POOL, "R3 no charge", occ(0), RSV + POOL);
        // R6 reserve guaranteed while pool full
        step(1, 1, 32, 0, 0, 0);
        chk(res_accept == 1, "R6 reserve admit", res_accept, 1);
        step(1, 1, 1, 0, 0, 0);
        chk(res_accept == 0 && occ(1) == 32, "R6 past reserve", occ(1), 32);
        // R7 shared first on release
        step(0, 0, 0, 1, 0, 10);
        chk(pool_used == POOL - 10, "R7 shared first", int'(pool_used), POOL - 10);
        // R8 simultaneous enqueue and release
        step(1, 2, 40, 1, 0, 30);
        chk(res_accept == 1 && occ(2) == 40, "R8 enq side", occ(2), 40);
        chk(occ(0) == 120 && pool_used == 96, "R8 rel side", int'(pool_used), 96);
        step(1, 0, 5, 1, 0, 7);
        chk(occ(0) == 118, "R8 same port", occ(0), 118);
        // R3 zero length
        step(1, 3, 0, 0, 0, 0);
        chk(res_accept == 0 && occ(3) == 0, "R3 zero length", occ(3), 0);
        // R9 per-queue depth
        step(1, 0, 2, 0, 0, 0);
        chk(res_depth == 118, "R9 queue depth", int'(res_depth), 118);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int rp, c;
            rp = $urandom_range(N - 1);
            c = imin($urandom_range(40), mres[rp] + mshr[rp]);
            step($urandom_range(3) != 0, $urandom_range(N - 1), $urandom_range(63),
                 $urandom_range(1) == 1, rp, c);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            done = 1; checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule